// File: doc/BRIEF.md
# Decoded Frame Output Sequencer

This block drives decoded codewords out onto a byte-wide channel bus, one byte per output clock cycle. Each codeword on the bus has three consecutive segments: information bytes, then check (parity) bytes, then an optional run of filler (gap) bytes. The lengths of the three segments are set at run time through configuration inputs. A gap length of zero is legal. The information and check lengths must be at least one.

Bytes come from an upstream byte queue. The queue shows an availability flag, and the block takes a byte on every cycle where one is available. The block tracks where it is inside the codeword, so it knows whether each byte is information, check or filler. Next to every byte it drives three registered flags:

- a qualifier, high only for information bytes;
- an error flag, raised across the information and check bytes of a codeword that the decoder could not repair;
- a one-cycle frame-start pulse, which travels with the byte that upstream marked as the first of a frame.

Filler bytes pass through unchanged. When the queue runs dry, the bus holds its last value and all three flags drop.

Top module: `frame_out_seq`

## Requirements
- R1: Every output (byte bus, qualifier, error, frame start) is a register on `clk`. A byte taken at a rising edge appears on the outputs just after that same edge.
- R2: `out_valid` is 1 for every byte in the information segment (positions 0 to `cfg_data_len`-1 of a codeword).
- R3: `out_valid` is 0 for check bytes and for filler bytes.
- R4: The uncorrectable flag is sampled only with the first information byte of a codeword. When it is 1, `out_err` is 1 on every information byte and every check byte of that codeword. `in_uncorr` on any other byte has no effect.
- R5: `out_err` is 0 on every filler byte, even when the codeword just before it was uncorrectable.
- R6: `out_fstart` is 1 for exactly the one output cycle that carries the byte taken with `in_fstart`=1. It is 0 on every other cycle.
- R7: With `cfg_gap_len`=0, the last check byte is followed directly by the first information byte of the next codeword.
- R8: Every byte, filler bytes included, appears on `out_byte` with its value unchanged and in arrival order.
- R9: In a cycle with `in_avail`=0, no byte is taken. `out_byte` keeps its previous value, all three flags are 0, and the sequence then resumes with no byte dropped or repeated.
- R10: Synchronous active-high `rst` returns the sequencer to position 0 of a codeword, clears all flags and sets `out_byte` to 0. `in_take` is 0 while `rst` is high.
- R11: Segment lengths of 1 are sequenced correctly, and the lengths may be changed between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_data_len | input | LEN_W | Information bytes per codeword (at least 1) |
| cfg_par_len | input | LEN_W | Check bytes per codeword (at least 1) |
| cfg_gap_len | input | LEN_W | Filler bytes per codeword (0 allowed) |
| in_avail | input | 1 | Upstream queue holds a byte |
| in_byte | input | BYTE_W | Byte at the head of the queue |
| in_uncorr | input | 1 | Codeword is uncorrectable (read with its first byte) |
| in_fstart | input | 1 | Head byte is the first byte of a frame |
| in_take | output | 1 | Pops the head byte from the queue |
| out_byte | output | BYTE_W | Channel byte bus |
| out_valid | output | 1 | Information-byte qualifier |
| out_err | output | 1 | Uncorrectable-codeword flag |
| out_fstart | output | 1 | Frame-start pulse |

## Verification
Three pairs of events can fall in the same cycle:

- An error codeword begins on the same byte that carries the frame-start marker. The error flag and the frame-start pulse then both rise on that byte.
- A queue stall lands exactly on a segment or codeword boundary.
- A reset arrives in the middle of a codeword.

The bench provokes all three by drawing stalls at random between any two bytes, by marking frame starts on codewords that are also drawn uncorrectable, and by resetting partway through a codeword. A behavioural position model predicts all four outputs, and every cycle is compared against it. On each mismatch the bench reports the byte, qualifier, error and frame-start values separately.

// File: rtl/frame_out_seq_pkg.sv
package frame_out_seq_pkg;

    typedef enum logic [1:0] {
        SEG_DATA   = 2'd0,
        SEG_PARITY = 2'd1,
        SEG_GAP    = 2'd2
    } seg_e;

    typedef struct packed {
        logic valid;
        logic err;
        logic fstart;
    } lane_flags_t;

    localparam lane_flags_t FLAGS_IDLE = '{valid: 1'b0, err: 1'b0, fstart: 1'b0};

    // Segment that follows the current one once it is exhausted.
    function automatic seg_e seg_after(input seg_e cur, input logic gap_empty);
        seg_e nxt;
        case (cur)
            SEG_DATA:   nxt = SEG_PARITY;
            SEG_PARITY: nxt = gap_empty ? SEG_DATA : SEG_GAP;
            default:    nxt = SEG_DATA;
        endcase
        return nxt;
    endfunction

    // Qualifier and error flags for one byte of a given segment.
    function automatic lane_flags_t flags_for(input seg_e seg, input logic cw_bad,
                                              input logic fstart);
        lane_flags_t f;
        f.valid  = (seg == SEG_DATA);
        f.err    = cw_bad && (seg != SEG_GAP);
        f.fstart = fstart;
        return f;
    endfunction

endpackage

// File: rtl/frame_out_seq_tracker.sv
module frame_out_seq_tracker
    import frame_out_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [LEN_W-1:0] len_data,
    input  logic [LEN_W-1:0] len_par,
    input  logic [LEN_W-1:0] len_gap,
    output seg_e             seg,
    output logic             cw_first
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seg_e             seg_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] seg_len;
    logic             seg_last;

    always_comb begin
        case (seg_q)
            SEG_DATA:   seg_len = len_data;
            SEG_PARITY: seg_len = len_par;
            default:    seg_len = len_gap;
        endcase
        seg_last = (cnt_q == (seg_len - ONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_DATA;
            cnt_q <= '0;
        end else if (adv) begin
            if (seg_last) begin
                seg_q <= seg_after(seg_q, len_gap == '0);
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign seg      = seg_q;
    assign cw_first = (seg_q == SEG_DATA) && (cnt_q == '0);

endmodule

// File: rtl/frame_out_seq_err.sv
module frame_out_seq_err (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic cw_first,
    input  logic in_uncorr,
    output logic cw_bad
);

    logic bad_q;

    // On the opening byte the live flag decides; afterwards the held copy.
    assign cw_bad = cw_first ? in_uncorr : bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q <= 1'b0;
        end else if (adv && cw_first) begin
            bad_q <= in_uncorr;
        end
    end

endmodule

// File: rtl/frame_out_seq_lane.sv
module frame_out_seq_lane
    import frame_out_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [BYTE_W-1:0] byte_in,
    input  lane_flags_t       flags_in,
    output logic [BYTE_W-1:0] byte_out,
    output lane_flags_t       flags_out
);

    logic [BYTE_W-1:0] byte_q;
    lane_flags_t       flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q  <= '0;
            flags_q <= FLAGS_IDLE;
        end else if (adv) begin
            byte_q  <= byte_in;
            flags_q <= flags_in;
        end else begin
            flags_q <= FLAGS_IDLE;
        end
    end

    assign byte_out  = byte_q;
    assign flags_out = flags_q;

endmodule

// File: rtl/frame_out_seq.sv
module frame_out_seq
    import frame_out_seq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_data_len,
    input  logic [LEN_W-1:0]  cfg_par_len,
    input  logic [LEN_W-1:0]  cfg_gap_len,
    input  logic              in_avail,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_uncorr,
    input  logic              in_fstart,
    output logic              in_take,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              out_err,
    output logic              out_fstart
);

    seg_e        seg;
    logic        cw_first;
    logic        cw_bad;
    logic        adv;
    lane_flags_t flags_next;
    lane_flags_t flags_reg;

    assign adv     = in_avail && !rst;
    assign in_take = adv;

    frame_out_seq_tracker #(
        .LEN_W (LEN_W)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .len_data (cfg_data_len),
        .len_par  (cfg_par_len),
        .len_gap  (cfg_gap_len),
        .seg      (seg),
        .cw_first (cw_first)
    );

    frame_out_seq_err u_err (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .cw_first  (cw_first),
        .in_uncorr (in_uncorr),
        .cw_bad    (cw_bad)
    );

    assign flags_next = flags_for(seg, cw_bad, in_fstart);

    frame_out_seq_lane #(
        .BYTE_W (BYTE_W)
    ) u_lane (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .byte_in   (in_byte),
        .flags_in  (flags_next),
        .byte_out  (out_byte),
        .flags_out (flags_reg)
    );

    assign out_valid  = flags_reg.valid;
    assign out_err    = flags_reg.err;
    assign out_fstart = flags_reg.fstart;

endmodule

// File: rtl/frame_out_seq_chk.sv
module frame_out_seq_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_avail,
    input logic              in_take,
    input logic [BYTE_W-1:0] in_byte,
    input logic              in_fstart,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_valid,
    input logic              out_err,
    input logic              out_fstart
);

    AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_avail)) |-> (!out_valid && !out_err && !out_fstart)); // R9

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_avail)) |-> $stable(out_byte)); // R9

    AST_BYTE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_avail)) |-> (out_byte == $past(in_byte))); // R8

    AST_FSTART_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_avail)) |-> (out_fstart == $past(in_fstart))); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_err && !out_fstart && out_byte == '0)); // R10

    AST_NO_TAKE_IN_RESET: assert property (@(posedge clk)
        rst |-> !in_take); // R10

endmodule

bind frame_out_seq frame_out_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_avail   (in_avail),
    .in_take    (in_take),
    .in_byte    (in_byte),
    .in_fstart  (in_fstart),
    .out_byte   (out_byte),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_fstart (out_fstart)
);

// File: tb/frame_out_seq_tb.sv
`timescale 1ns/1ps
module frame_out_seq_tb;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LEN_W-1:0]  cfg_data_len = 8'd4;
    logic [LEN_W-1:0]  cfg_par_len  = 8'd2;
    logic [LEN_W-1:0]  cfg_gap_len  = 8'd2;
    logic              in_avail  = 1'b0;
    logic [BYTE_W-1:0] in_byte   = '0;
    logic              in_uncorr = 1'b0;
    logic              in_fstart = 1'b0;
    logic              in_take;
    logic [BYTE_W-1:0] out_byte;
    logic              out_valid, out_err, out_fstart;

    always #4 clk = ~clk;

    frame_out_seq #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_data_len(cfg_data_len), .cfg_par_len(cfg_par_len), .cfg_gap_len(cfg_gap_len),
        .in_avail(in_avail), .in_byte(in_byte), .in_uncorr(in_uncorr), .in_fstart(in_fstart),
        .in_take(in_take), .out_byte(out_byte), .out_valid(out_valid),
        .out_err(out_err), .out_fstart(out_fstart)
    );

    int vectors = 0;
    int fails   = 0;
    string phase = "R10";

    // Behavioural model state
    int pos = 0;
    bit m_bad = 0;
    logic [7:0] e_byte = 0;
    bit e_valid = 0, e_err = 0, e_fs = 0, e_take = 0;
    bit was_stall = 0;

    function automatic void cmp(string tag, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endfunction

    task automatic step(bit av, logic [7:0] b, bit unc, bit fs, bit r);
        int total;
        int dl;
        int pl;
        rst = r; in_avail = av; in_byte = b; in_uncorr = unc; in_fstart = fs;
        #1;
        e_take = av && !r;
        cmp("R10 in_take", in_take, e_take);
        @(posedge clk);
        dl = cfg_data_len; pl = cfg_par_len;
        total = dl + pl + int'(cfg_gap_len);
        was_stall = 0;
        if (r) begin
            pos = 0; m_bad = 0; e_byte = 0; e_valid = 0; e_err = 0; e_fs = 0;
        end else if (av) begin
            if (pos == 0) m_bad = unc;
            e_byte  = b;
            e_valid = (pos < dl);
            e_err   = m_bad && (pos < dl + pl);
            e_fs    = fs;
            pos = (pos + 1) % total;
        end else begin
            e_valid = 0; e_err = 0; e_fs = 0; was_stall = 1;
        end
        @(negedge clk);
        vectors++;
        // R1: outputs compared one edge after the byte is taken
        cmp(was_stall ? "R9 out_byte" : "R8 out_byte", out_byte, e_byte);
        cmp(e_valid ? "R2 out_valid" : "R3 out_valid", out_valid, e_valid);
        cmp((e_valid || e_err) ? "R4 out_err" : "R5 out_err", out_err, e_err);
        cmp("R6 out_fstart", out_fstart, e_fs);
    endtask

    task automatic do_reset(int n);
        for (int i = 0; i < n; i++) step(0, 8'($urandom), $urandom % 2, $urandom % 2, 1);
    endtask

    // Streams ncw codewords with random stalls; in_uncorr is random on non-first bytes (R4).
    task automatic run_cfg(int dl, int pl, int gl, int ncw, int stall_pct, string ph);
        phase = ph;
        cfg_data_len = 8'(dl); cfg_par_len = 8'(pl); cfg_gap_len = 8'(gl);
        do_reset(2);
        for (int cw = 0; cw < ncw; cw++) begin
            bit bad = ($urandom % 3) == 0;
            for (int b = 0; b < dl + pl + gl; b++) begin
                while (($urandom % 100) < stall_pct)
                    step(0, 8'($urandom), $urandom % 2, $urandom % 2, 0);
                step(1, 8'($urandom), (b == 0) ? bad : 1'($urandom), (b == 0) && (cw % 3 == 0), 0);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        phase = "R10";
        do_reset(3);
        run_cfg(4, 2, 2, 30, 25, "R2R3R5");
        run_cfg(3, 2, 0, 30, 20, "R7");
        run_cfg(1, 1, 1, 30, 30, "R11");
        run_cfg(1, 1, 0, 20, 0, "R11");
        run_cfg(6, 3, 4, 20, 40, "R9");
        // R10: reset in the middle of a codeword, then restart from position 0
        phase = "R10";
        for (int i = 0; i < 5; i++) step(1, 8'($urandom), 1, 0, 0);
        do_reset(1);
        run_cfg(6, 3, 4, 6, 10, "R10");
        // R4/R6: frame start and error on the same first byte
        run_cfg(2, 2, 1, 12, 15, "R4R6");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog [%s] actual=hung expected=done", phase);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule